// File: doc/BRIEF.md
# Junction Temperature Monitor with Hysteretic Over-Temperature Trip

This block takes a digitised junction temperature in whole degrees Celsius and turns it into a linear monitor code, expressed as an integer number of millivolts. The code starts at 600 at 0 °C and rises by 8 per degree. Signed arithmetic keeps temperatures below zero correct. An over-temperature detector trips above an upper threshold and releases only below a lower threshold. While it is tripped, the monitor code is replaced by a fixed fault level and a flag is raised toward the fault output. The trip only reports. It has no other effect.

The monitor code and the trip are qualified by a power-on-ready input. The output becomes valid after that input has been held high for a programmable number of clock cycles, which is 125 µs at the intended clock. Several monitors can share one monitor bus. The block resolves that bus to the largest of its own code and the codes of its neighbours, so the hottest contributor, or any channel in its fault state, wins.

Top module: `thermal_monitor`

## Requirements
- R1: While rst_ni is low, code_o is 0, ot_o is 0 and valid_o is 0.
- R2: valid_o becomes 1 after por_ok_i has been sampled high on READY_CYCLES consecutive rising clock edges. It is 0 after READY_CYCLES-1 such edges, and it returns to 0 on the first edge at which por_ok_i is sampled low.
- R3: While valid_o is 0, code_o is 0. On the edge that follows a cycle with valid_o at 0, ot_o is 0, whatever the temperature.
- R4: When valid and not tripped, code_o equals 600 + 8*T, where T is the signed temperature sampled on the previous edge. For example, 25 °C gives 800, 0 °C gives 600 and -40 °C gives 280.
- R5: When valid, a sampled temperature strictly above 140 sets ot_o on that edge. A temperature of exactly 140 does not set it.
- R6: Once set, ot_o clears only when a sampled temperature is strictly below 125. Any value from 125 to 140 inclusive holds the current state.
- R7: While ot_o is 1 and the output is valid, code_o is the fault level 2500.
- R8: code_o never exceeds 2500 and never goes below 0. A linear value below 0 saturates to 0.
- R9: bus_code_o is the largest of code_o and every neighbour code, in the same cycle. Neighbour k occupies bits [k*CODE_W +: CODE_W] of peer_code_i, and a neighbour code above 2500 is passed through unchanged when it is the largest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| por_ok_i | input | 1 | Supplies have reached their power-on level |
| temp_c_i | input | TEMP_W (9) | Signed junction temperature in °C |
| peer_code_i | input | N_PEER*CODE_W (36) | Packed monitor codes driven by neighbouring channels |
| code_o | output | CODE_W (12) | This channel's monitor code in mV |
| bus_code_o | output | CODE_W (12) | Resolved shared bus value, the largest contributor |
| ot_o | output | 1 | Over-temperature flag feeding the fault output |
| valid_o | output | 1 | The monitor output is valid |

## Verification
The assertions take for granted that temp_c_i and por_ok_i are stable around the rising edge. They also assume that the temperature thresholds lie inside the signed range of TEMP_W, so that comparisons near 125 and 140 cannot wrap. The stimulus changes every input on the falling edge, keeps temperatures inside the 9-bit signed range, and spends several cycles with the temperature between the two thresholds, both from below and from above. This lets the hold-state properties see both trip states.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int DefCodeW = 12;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/tmon_ready_timer.sv
module tmon_ready_timer #(
  parameter int READY_CYCLES = 15625
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ok_i,
  output logic ready_o
);
  localparam int CntW = $clog2(READY_CYCLES + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(READY_CYCLES);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!por_ok_i)    cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == CntMax);

  // R2: dropping the power-on flag withdraws validity at the next edge
  a_r2_drop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> !ready_o);
  // R2: validity never appears out of a cycle without the power-on flag
  a_r2_needs_por: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(por_ok_i));
endmodule

// File: rtl/tmon_trip_hyst.sv
module tmon_trip_hyst #(
  parameter int TEMP_W    = 9,
  parameter int TRIP_HI_C = 140,
  parameter int TRIP_LO_C = 125
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ready_i,
  input  logic signed [TEMP_W-1:0] temp_c_i,
  output logic                     ot_o
);
  logic ot_q;
  int   t_int;

  assign t_int = int'(temp_c_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ot_q <= 1'b0;
    else if (!ready_i)          ot_q <= 1'b0;
    else if (t_int > TRIP_HI_C) ot_q <= 1'b1;
    else if (t_int < TRIP_LO_C) ot_q <= 1'b0;
  end

  assign ot_o = ot_q;

  a_r3_idle_no_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !ot_o);
  a_r5_trip_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && t_int > TRIP_HI_C) |=> ot_o);
  a_r6_release_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && t_int < TRIP_LO_C) |=> !ot_o);
  a_r6_hold_in_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && t_int >= TRIP_LO_C && t_int <= TRIP_HI_C) |=> $stable(ot_o));
endmodule

// File: rtl/tmon_code_map.sv
module tmon_code_map #(
  parameter int TEMP_W   = 9,
  parameter int CODE_W   = tmon_pkg::DefCodeW,
  parameter int BASE_MV  = 600,
  parameter int SLOPE_MV = 8,
  parameter int FAULT_MV = 2500
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [TEMP_W-1:0] temp_c_i,
  input  logic                     ready_i,
  input  logic                     ot_i,
  output logic [CODE_W-1:0]        code_o
);
  localparam logic [CODE_W-1:0] FaultCode = CODE_W'(FAULT_MV);

  logic signed [TEMP_W-1:0] temp_q;
  logic [CODE_W-1:0]        lin_code;
  int                       lin_mv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) temp_q <= '0;
    else         temp_q <= temp_c_i;
  end

  always_comb begin
    lin_mv   = BASE_MV + SLOPE_MV * int'(temp_q);
    lin_code = CODE_W'(tmon_pkg::clamp_int(lin_mv, 0, FAULT_MV));
  end

  always_comb begin
    if (!ready_i)  code_o = '0;
    else if (ot_i) code_o = FaultCode;
    else           code_o = lin_code;
  end

  a_r8_code_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o <= FaultCode);
  a_r3_code_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> code_o == '0);
endmodule

// File: rtl/tmon_bus_max.sv
module tmon_bus_max #(
  parameter int CODE_W = tmon_pkg::DefCodeW,
  parameter int N_PEER = 3
) (
  input  logic [CODE_W-1:0]        own_i,
  input  logic [N_PEER*CODE_W-1:0] peer_i,
  output logic [CODE_W-1:0]        bus_o
);
  logic [CODE_W-1:0] peer_a [N_PEER];

  for (genvar k = 0; k < N_PEER; k++) begin : g_unpack
    assign peer_a[k] = peer_i[k*CODE_W +: CODE_W];
  end

  always_comb begin
    bus_o = own_i;
    for (int k = 0; k < N_PEER; k++) begin
      if (peer_a[k] > bus_o) bus_o = peer_a[k];
    end
  end

  // R9: the resolved bus never falls below this channel's own code
  always_comb begin
    a_r9_bus_ge_own: assert (bus_o >= own_i);
  end
endmodule

// File: rtl/thermal_monitor.sv
module thermal_monitor #(
  parameter int TEMP_W       = 9,
  parameter int CODE_W       = tmon_pkg::DefCodeW,
  parameter int N_PEER       = 3,
  parameter int BASE_MV      = 600,
  parameter int SLOPE_MV     = 8,
  parameter int FAULT_MV     = 2500,
  parameter int TRIP_HI_C    = 140,
  parameter int TRIP_LO_C    = 125,
  parameter int READY_CYCLES = 15625
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     por_ok_i,
  input  logic signed [TEMP_W-1:0] temp_c_i,
  input  logic [N_PEER*CODE_W-1:0] peer_code_i,
  output logic [CODE_W-1:0]        code_o,
  output logic [CODE_W-1:0]        bus_code_o,
  output logic                     ot_o,
  output logic                     valid_o
);
  logic ready;
  logic ot;

  tmon_ready_timer #(.READY_CYCLES(READY_CYCLES)) u_timer (
    .clk_i, .rst_ni, .por_ok_i, .ready_o(ready)
  );

  tmon_trip_hyst #(
    .TEMP_W(TEMP_W), .TRIP_HI_C(TRIP_HI_C), .TRIP_LO_C(TRIP_LO_C)
  ) u_trip (
    .clk_i, .rst_ni, .ready_i(ready), .temp_c_i, .ot_o(ot)
  );

  tmon_code_map #(
    .TEMP_W(TEMP_W), .CODE_W(CODE_W), .BASE_MV(BASE_MV),
    .SLOPE_MV(SLOPE_MV), .FAULT_MV(FAULT_MV)
  ) u_map (
    .clk_i, .rst_ni, .temp_c_i, .ready_i(ready), .ot_i(ot), .code_o
  );

  tmon_bus_max #(.CODE_W(CODE_W), .N_PEER(N_PEER)) u_bus (
    .own_i(code_o), .peer_i(peer_code_i), .bus_o(bus_code_o)
  );

  assign ot_o    = ot;
  assign valid_o = ready;

  a_r7_fault_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_o && valid_o) |-> code_o == CODE_W'(FAULT_MV));
endmodule

// File: tb/thermal_monitor_tb.sv
`timescale 1ns/1ps
module thermal_monitor_tb;
  localparam int TW = 9;
  localparam int CW = 12;
  localparam int NP = 3;
  localparam int RDY = 40;
  localparam int NV = 11;

  // temp, peer0, peer1, peer2, expected code, expected bus, expected ot
  localparam int V_T   [NV] = '{25, -40, 0, 140, 141, 130, 125, 124, 135, 100, -128};
  localparam int V_P0  [NV] = '{0, 0, 700, 0, 0, 0, 0, 0, 0, 900, 0};
  localparam int V_P1  [NV] = '{0, 0, 300, 0, 0, 0, 0, 0, 0, 3000, 0};
  localparam int V_P2  [NV] = '{0, 0, 100, 0, 0, 0, 0, 0, 0, 50, 0};
  localparam int V_CODE[NV] = '{800, 280, 600, 1720, 2500, 2500, 2500, 1592, 1680, 1400, 0};
  localparam int V_BUS [NV] = '{800, 280, 700, 1720, 2500, 2500, 2500, 1592, 1680, 3000, 0};
  localparam int V_OT  [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por_ok = 1'b0;
  logic signed [TW-1:0] temp = '0;
  logic [NP*CW-1:0] peers = '0;
  logic [CW-1:0] code, bus;
  logic ot, valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  thermal_monitor #(.READY_CYCLES(RDY)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ok_i(por_ok), .temp_c_i(temp),
    .peer_code_i(peers), .code_o(code), .bus_code_o(bus), .ot_o(ot), .valid_o(valid)
  );

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int t, input int p0, input int p1, input int p2);
    @(negedge clk);
    temp  = TW'(t);
    peers = {CW'(p2), CW'(p1), CW'(p0)};
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    temp = 9'sd25;
    #20;
    check(int'(code), 0, "R1 code");
    check(int'(ot), 0, "R1 ot");
    check(int'(valid), 0, "R1 valid");
    @(negedge clk) rst_ni = 1'b1;

    // R3: hot but not ready; R9: peer wins the bus
    drive(200, 500, 0, 0);
    edge_wait();
    check(int'(valid), 0, "R3 valid");
    check(int'(ot), 0, "R3 ot");
    check(int'(code), 0, "R3 code");
    check(int'(bus), 500, "R9 bus idle");

    // R2: ready after RDY edges, still hot so trip must stay low (R3)
    @(negedge clk) por_ok = 1'b1;
    peers = '0;
    for (int i = 1; i <= RDY; i++) begin
      edge_wait();
      if (i == RDY - 1) begin
        check(int'(valid), 0, "R2 early");
        check(int'(ot), 0, "R3 ot before ready");
      end
    end
    check(int'(valid), 1, "R2 ready");

    // R4..R9 vector walk
    for (int v = 0; v < NV; v++) begin
      drive(V_T[v], V_P0[v], V_P1[v], V_P2[v]);
      edge_wait();
      check(int'(code), V_CODE[v], "R4-table code");
      check(int'(bus), V_BUS[v], "R9 table bus");
      check(int'(ot), V_OT[v], "R5_R6 table ot");
    end

    // R2/R3: power-on loss while tripped
    drive(150, 0, 0, 0);
    edge_wait();
    check(int'(ot), 1, "R5 trip");
    check(int'(code), 2500, "R7 fault level");
    @(negedge clk) por_ok = 1'b0;
    edge_wait();
    check(int'(valid), 0, "R2 drop");
    check(int'(code), 0, "R3 code after drop");
    edge_wait();
    check(int'(ot), 0, "R3 ot after drop");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule